// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block drives the control and data pins of an asynchronous 8-bit raw NAND flash device, one access at a time. A host-side request names one of four kinds of bus cycle: command latch, address latch, data write or data read. The sequencer then runs that cycle through three timed phases: setup, strobe and hold. Each phase has its own programmable length, and the read and write cycles use separate settings. After the hold phase the block can wait for a programmed time before it treats the device's ready/busy line as valid again.

All timing comes from one 32-bit configuration word that holds eight 4-bit fields. The word is captured when a request is accepted, so the host may change it while an access is running. A separate input holds chip enable active between accesses, so that a multi-cycle device operation stays selected. Read data is captured on the last clock of the strobe phase and is reported with a one-cycle valid pulse. The ready level is sampled only while the sequencer is idle or as it returns to idle.

Top module: `nand_bus_sequencer`

## Requirements
- R1: After reset the outputs are idle: nandCeN=1, nandCle=0, nandAle=0, nandWeN=1, nandReN=1, nandDoe=0, busy=0, rdValid=0, devReady=0.
- R2: The timing word is split into 4-bit fields. The read set is setup [3:0], hold [7:4], strobe width [11:8] and ready wait [15:12]. The write set is setup [19:16], hold [23:20], strobe width [27:24] and ready wait [31:28]. A setup, width or hold value n gives a phase of n+1 clocks, in the order setup, strobe, hold.
- R3: reqKind selects the cycle: 0 is command, 1 is address, 2 is data write, 3 is data read. nandCle is high through setup, strobe and hold of a command cycle, and only then. nandAle is high through the same phases of an address cycle, and only then.
- R4: In command, address and write cycles, nandWeN is low only during the strobe phase. nandDoe is high and nandDout holds the request byte through setup, strobe and hold.
- R5: In a read cycle, nandReN is low only during the strobe phase and nandDoe stays low. nandDin is captured on the last strobe clock. rdData shows that byte from the next cycle on, and rdValid is high for exactly that next cycle.
- R6: A ready-wait value n adds 2*n idle-pin clocks after the hold phase, during which busy stays high. With n=0 no clocks are added.
- R7: devReady (1 = ready) loads nandRb at every clock edge where the sequencer is idle and not accepting a request, and at the edge that ends an access. nandRb changes at any other time have no effect on it.
- R8: A request is accepted when reqValid is high in a cycle where busy is low. busy is high from the next cycle until the access ends. Requests made while busy is high are ignored.
- R9: While forceCeActive is 1, nandCeN is low even when the sequencer is idle.
- R10: The timing word is captured at acceptance. Changing timingWord during an access does not alter that access's phase lengths.
- R11: nandCeN is low in every cycle in which busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| timingWord | input | 32 | Eight 4-bit phase-length fields |
| forceCeActive | input | 1 | Hold chip enable active while idle |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqKind | input | 2 | 0 command, 1 address, 2 write, 3 read |
| reqData | input | 8 | Byte for command, address or write cycles |
| busy | output | 1 | Access in progress |
| rdData | output | 8 | Last captured read byte |
| rdValid | output | 1 | One-cycle pulse when rdData is new |
| devReady | output | 1 | Sampled device ready level |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDout | output | 8 | Data bus value to drive |
| nandDoe | output | 1 | Data bus output enable |
| nandDin | input | 8 | Data bus value from the device |
| nandRb | input | 1 | Device ready/busy line, 1 = ready |

## Verification
The properties assume that nandRb and nandDin are already synchronous to clk. They also assume reqKind and reqData are valid in any cycle where reqValid is high and busy is low. Nothing is assumed about timingWord outside the acceptance cycle. The stimulus changes every input only on the falling clock edge. It drives nandRb and nandDin from free-running patterns, so ready edges and data changes fall inside every phase, including the ready wait. Requests are raised during busy cycles and withdrawn in the first idle cycle, so no access is accepted by accident. The timing word is changed in the middle of one access.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_WAIT
  } phase_t;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_t;

  // Strobes from the control FSM to the pin datapath
  typedef struct packed {
    logic accept;     // request taken this cycle
    logic active;     // access in progress
    logic latchOn;    // setup, strobe or hold phase
    logic strobeOn;   // strobe phase
    logic capture;    // last strobe clock of a read
    logic sampleRdy;  // next cycle is idle: sample ready line
  } nbs_strb_t;

  localparam int FIELDS_PER_SET = 4;
  localparam int IDX_SETUP = 0;
  localparam int IDX_HOLD  = 1;
  localparam int IDX_WIDTH = 2;
  localparam int IDX_WAIT  = 3;

endpackage

// File: rtl/nbs_ctrl.sv
module nbs_ctrl
  import nbs_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqIsRead,
  input  logic [8*FIELD_W-1:0]     timingWord,
  output logic                     busy,
  output nbs_strb_t                strb
);

  localparam int CNT_W  = FIELD_W + 1;
  localparam int CFG_W  = 2 * FIELDS_PER_SET * FIELD_W;
  localparam int WR_OFS = FIELDS_PER_SET;

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic               isRdQ;
  logic [CFG_W-1:0]   cfgQ;
  logic [FIELD_W-1:0] fld [FIELDS_PER_SET];
  logic [FIELD_W-1:0] inSetup;
  logic               cntDone;
  logic               waitZero;

  // Active field set, chosen by the captured direction
  for (genvar g = 0; g < FIELDS_PER_SET; g++) begin : g_fld
    assign fld[g] = isRdQ ? cfgQ[g*FIELD_W +: FIELD_W]
                          : cfgQ[(g+WR_OFS)*FIELD_W +: FIELD_W];
  end

  assign inSetup  = reqIsRead ? timingWord[IDX_SETUP*FIELD_W +: FIELD_W]
                              : timingWord[(IDX_SETUP+WR_OFS)*FIELD_W +: FIELD_W];
  assign cntDone  = (cnt == '0);
  assign waitZero = (fld[IDX_WAIT] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      isRdQ <= 1'b0;
      cfgQ  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            phase <= PH_SETUP;
            cnt   <= CNT_W'(inSetup);
            isRdQ <= reqIsRead;
            cfgQ  <= timingWord;
          end
        end
        PH_SETUP: begin
          if (cntDone) begin
            phase <= PH_STROBE;
            cnt   <= CNT_W'(fld[IDX_WIDTH]);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cntDone) begin
            phase <= PH_HOLD;
            cnt   <= CNT_W'(fld[IDX_HOLD]);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cntDone) begin
            if (waitZero) begin
              phase <= PH_IDLE;
            end else begin
              phase <= PH_WAIT;
              cnt   <= {fld[IDX_WAIT], 1'b0} - 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_WAIT: begin
          if (cntDone) phase <= PH_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.accept    = (phase == PH_IDLE) && reqValid;
    strb.active    = (phase != PH_IDLE);
    strb.latchOn   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    strb.strobeOn  = (phase == PH_STROBE);
    strb.capture   = (phase == PH_STROBE) && cntDone && isRdQ;
    strb.sampleRdy = ((phase == PH_IDLE) && !reqValid)
                   || ((phase == PH_HOLD) && cntDone && waitZero)
                   || ((phase == PH_WAIT) && cntDone);
  end

  assign busy = strb.active;

endmodule

// File: rtl/nbs_datapath.sv
module nbs_datapath
  import nbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  nbs_strb_t         strb,
  input  logic [1:0]        reqKind,
  input  logic [DATA_W-1:0] reqData,
  input  logic              forceCeActive,
  input  logic [DATA_W-1:0] nandDin,
  input  logic              nandRb,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              devReady,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [DATA_W-1:0] nandDout,
  output logic              nandDoe
);

  logic [1:0]        kindQ;
  logic [DATA_W-1:0] dataQ;
  logic              isWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ    <= OP_CMD;
      dataQ    <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
      devReady <= 1'b0;
    end else begin
      if (strb.accept) begin
        kindQ <= reqKind;
        dataQ <= reqData;
      end
      if (strb.capture) rdData <= nandDin;
      rdValid <= strb.capture;
      if (strb.sampleRdy) devReady <= nandRb;
    end
  end

  assign isWrite  = (kindQ != OP_READ);
  assign nandCeN  = !(strb.active || forceCeActive);
  assign nandCle  = strb.latchOn && (kindQ == OP_CMD);
  assign nandAle  = strb.latchOn && (kindQ == OP_ADDR);
  assign nandWeN  = !(strb.strobeOn && isWrite);
  assign nandReN  = !(strb.strobeOn && !isWrite);
  assign nandDoe  = strb.latchOn && isWrite;
  assign nandDout = nandDoe ? dataQ : '0;

endmodule

// File: rtl/nand_bus_sequencer.sv
module nand_bus_sequencer
  import nbs_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int DATA_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [8*FIELD_W-1:0] timingWord,
  input  logic                 forceCeActive,
  input  logic                 reqValid,
  input  logic [1:0]           reqKind,
  input  logic [DATA_W-1:0]    reqData,
  output logic                 busy,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid,
  output logic                 devReady,
  output logic                 nandCeN,
  output logic                 nandCle,
  output logic                 nandAle,
  output logic                 nandWeN,
  output logic                 nandReN,
  output logic [DATA_W-1:0]    nandDout,
  output logic                 nandDoe,
  input  logic [DATA_W-1:0]    nandDin,
  input  logic                 nandRb
);

  nbs_strb_t strb;

  nbs_ctrl #(.FIELD_W(FIELD_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqIsRead  (reqKind == OP_READ),
    .timingWord (timingWord),
    .busy       (busy),
    .strb       (strb)
  );

  nbs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .reqKind       (reqKind),
    .reqData       (reqData),
    .forceCeActive (forceCeActive),
    .nandDin       (nandDin),
    .nandRb        (nandRb),
    .rdData        (rdData),
    .rdValid       (rdValid),
    .devReady      (devReady),
    .nandCeN       (nandCeN),
    .nandCle       (nandCle),
    .nandAle       (nandAle),
    .nandWeN       (nandWeN),
    .nandReN       (nandReN),
    .nandDout      (nandDout),
    .nandDoe       (nandDoe)
  );

endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              rdValid,
  input logic              devReady,
  input logic              nandCeN,
  input logic              nandCle,
  input logic              nandAle,
  input logic              nandWeN,
  input logic              nandReN,
  input logic [DATA_W-1:0] nandDout,
  input logic              nandDoe
);

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (nandWeN && nandReN && !nandCle && !nandAle && !nandDoe)); // R1

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle)); // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN)); // R4

  AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> nandDoe); // R4

  AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (nandDoe && $past(nandDoe)) |-> $stable(nandDout)); // R4

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandDoe); // R5

  AST_RDVALID_AFTER_RE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(!nandReN) && nandReN)); // R5

  AST_RDY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(devReady)); // R7

  AST_CE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !nandCeN); // R11

endmodule

bind nand_bus_sequencer nbs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .rdValid  (rdValid),
  .devReady (devReady),
  .nandCeN  (nandCeN),
  .nandCle  (nandCle),
  .nandAle  (nandAle),
  .nandWeN  (nandWeN),
  .nandReN  (nandReN),
  .nandDout (nandDout),
  .nandDoe  (nandDoe)
);

// File: tb/tb_nand_bus_sequencer.sv
`timescale 1ns/1ps
module tb_nand_bus_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] timingWord = '0;
  logic        forceCeActive = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = '0;
  logic [7:0]  reqData = '0;
  logic        busy, rdValid, devReady;
  logic [7:0]  rdData, nandDout, nandDin;
  logic        nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDoe;
  logic        nandRb = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nand_bus_sequencer dut (
    .clk(clk), .rstN(rstN), .timingWord(timingWord), .forceCeActive(forceCeActive),
    .reqValid(reqValid), .reqKind(reqKind), .reqData(reqData),
    .busy(busy), .rdData(rdData), .rdValid(rdValid), .devReady(devReady),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDout(nandDout), .nandDoe(nandDoe),
    .nandDin(nandDin), .nandRb(nandRb)
  );

  task automatic chk(input string req, input string name, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, name, act, exp, $time);
    end
  endtask

  // ---------------- free-running device-side patterns ----------------
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  initial nandDin = 8'h00;
  always @(negedge clk) nandDin <= 8'(cyc * 37 + 11);
  initial begin
    forever begin
      repeat (7) @(negedge clk);
      nandRb = ~nandRb;
    end
  end

  // ---------------- behavioural cycle model ----------------
  int k = 0;                     // position inside access, 0 = idle
  int mS, mW, mH, mR, mT, mKind;
  int mData = 0;
  int expRd = 0, expRdValid = 0, expRdy = 0;
  bit modelOn = 0;

  always begin
    @(posedge clk);
    if (!rstN) begin
      k = 0; expRd = 0; expRdValid = 0; expRdy = 0;
    end else begin
      int nk;
      // ready sampling at edges where the next cycle is idle
      if ((k == 0 && !reqValid) || (k != 0 && k == mT)) expRdy = nandRb;
      expRdValid = (k != 0 && mKind == 3 && k == mS + mW + 2) ? 1 : 0;
      if (expRdValid == 1) expRd = nandDin;
      if (k == 0) begin
        if (reqValid) begin
          mKind = reqKind;
          mData = reqData;
          if (reqKind == 2'd3) begin
            mS = timingWord[3:0];   mH = timingWord[7:4];
            mW = timingWord[11:8];  mR = timingWord[15:12];
          end else begin
            mS = timingWord[19:16]; mH = timingWord[23:20];
            mW = timingWord[27:24]; mR = timingWord[31:28];
          end
          mT = mS + mW + mH + 3 + 2 * mR;
          nk = 1;
        end else nk = 0;
      end else nk = (k == mT) ? 0 : k + 1;
      k = nk;
    end
    #1;
    if (modelOn) begin
      bit inLatch, inStrobe, wr;
      inLatch  = (k >= 1 && k <= mS + mW + mH + 3);
      inStrobe = (k >= mS + 2 && k <= mS + mW + 2);
      wr       = (mKind != 3);
      chk("R8",  "busy",    busy,    k != 0);
      chk("R11", "nandCeN", nandCeN, !(k != 0 || forceCeActive));
      chk("R3",  "nandCle", nandCle, inLatch && mKind == 0);
      chk("R3",  "nandAle", nandAle, inLatch && mKind == 1);
      chk("R4",  "nandWeN", nandWeN, !(inStrobe && wr));
      chk("R5",  "nandReN", nandReN, !(inStrobe && !wr));
      chk("R4",  "nandDoe", nandDoe, inLatch && wr);
      if (inLatch && wr) chk("R4", "nandDout", nandDout, mData);
      chk("R5",  "rdValid", rdValid, expRdValid);
      chk("R5",  "rdData",  rdData,  expRd);
      chk("R7",  "devReady", devReady, expRdy);
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_access(input string tag, input logic [1:0] kind, input logic [7:0] data,
                            input bit spam, input bit changeWord);
    int s, w, h, r, len;
    if (kind == 2'd3) begin
      s = timingWord[3:0]; h = timingWord[7:4]; w = timingWord[11:8]; r = timingWord[15:12];
    end else begin
      s = timingWord[19:16]; h = timingWord[23:20]; w = timingWord[27:24]; r = timingWord[31:28];
    end
    while (busy) @(negedge clk);
    reqKind = kind; reqData = data; reqValid = 1'b1;
    @(negedge clk);
    len = 0;
    if (spam) begin
      reqKind = 2'd0; reqData = 8'hEE;   // R8: must be ignored while busy
    end else reqValid = 1'b0;
    if (changeWord) timingWord = 32'hFFFF_FFFF;   // R10: must not alter this access
    while (busy) begin
      len++;
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk(tag, "busy length", len, s + w + h + 3 + 2 * r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "nandCeN", nandCeN, 1);   chk("R1", "nandCle", nandCle, 0);
    chk("R1", "nandAle", nandAle, 0);   chk("R1", "nandWeN", nandWeN, 1);
    chk("R1", "nandReN", nandReN, 1);   chk("R1", "nandDoe", nandDoe, 0);
    chk("R1", "busy", busy, 0);         chk("R1", "rdValid", rdValid, 0);
    chk("R1", "devReady", devReady, 0);
    rstN = 1'b1;
    modelOn = 1;
    @(negedge clk);

    // R2 distinct read and write field sets, ready wait on reads only
    timingWord = 32'h0012_1321;
    run_access("R2", 2'd0, 8'h70, 0, 0);
    run_access("R2", 2'd1, 8'h05, 0, 0);
    run_access("R2", 2'd2, 8'hA5, 0, 0);
    run_access("R6", 2'd3, 8'h00, 0, 0);

    // minimum timing: one clock per phase, no wait
    timingWord = 32'h0000_0000;
    run_access("R2", 2'd0, 8'hFF, 0, 0);
    run_access("R6", 2'd3, 8'h00, 0, 0);
    run_access("R2", 2'd2, 8'h3C, 0, 0);

    // long phases and waits on both sides
    timingWord = 32'h52F3_4A1F;
    run_access("R6", 2'd2, 8'h81, 0, 0);
    run_access("R6", 2'd3, 8'h00, 0, 0);

    // R8 requests while busy ignored
    timingWord = 32'h1213_2132;
    run_access("R8", 2'd3, 8'h00, 1, 0);
    run_access("R8", 2'd1, 8'h44, 1, 0);

    // R10 word changed mid-access
    timingWord = 32'h0121_2213;
    run_access("R10", 2'd2, 8'h99, 0, 1);
    timingWord = 32'h0121_2213;
    run_access("R10", 2'd3, 8'h00, 0, 1);

    // R9 forced chip enable while idle, and across accesses
    timingWord = 32'h0000_0101;
    forceCeActive = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "nandCeN forced idle", nandCeN, 0);
    run_access("R9", 2'd0, 8'h90, 0, 0);
    run_access("R9", 2'd3, 8'h00, 0, 0);
    chk("R9", "nandCeN forced after access", nandCeN, 0);
    forceCeActive = 1'b0;
    @(negedge clk);
    chk("R9", "nandCeN released", nandCeN, 1);

    // R7 idle ready tracking over several toggles
    repeat (20) @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule